// File: doc/BRIEF.md
# Serially Configured Four-Input Logic Cell

This block is one programmable logic element. It holds a sixteen-entry truth table, so it can compute any Boolean function of four inputs. The four logic inputs pick one entry of the table, and that entry is the combinational result. A register can sample the result on each clock. One mode bit chooses what the cell drives: the raw table result, or the sampled value.

The table bits and the mode bit form one serial shift chain. While `cfg_en` is high, each clock moves one bit in from `cfg_din` and moves the last bit of the chain out on `cfg_dout`. The `cfg_dout` output of one cell can drive the `cfg_din` input of the next cell, so many cells load from a single stream.

The chain order is fixed: `cfg_din` feeds table entry 0, entry i feeds entry i+1, entry 15 feeds the mode bit, and the mode bit drives `cfg_dout`. Loading one cell takes seventeen enabled clocks. The mode bit is sent first, then table entries 15 down to 0.

Top module: `lut_cell`

## Requirements
- R1: With `rst` high at a clock edge, the table, the mode bit and the output register all clear to 0. After that edge, `cell_out` and `cfg_dout` read 0.
- R2: On each clock edge with `cfg_en` high, the chain advances one place: entry 0 takes `cfg_din`, entry i takes entry i-1, and the mode bit takes entry 15. `cfg_dout` always shows the mode bit, so it repeats the value that entered `cfg_din` seventeen enabled clocks earlier.
- R3: On a clock edge with `cfg_en` low, neither the table nor the mode bit changes. `cfg_dout` keeps its value.
- R4: After seventeen enabled clocks, the first bit sent is the mode bit. Bit k of the stream (k counted from 1) is table entry 17-k. Entry j is the function value for the inputs whose unsigned binary value is j, with `lut_in[0]` as the least significant bit.
- R5: With mode bit 0, `cell_out` equals entry `lut_in` of the table in the same cycle, with no clock in the path.
- R6: With mode bit 1, `cell_out` equals the table result for the `lut_in` value present at the most recent clock edge that had `cfg_en` low.
- R7: The output register does not change on clock edges with `cfg_en` high. With mode bit 1, `cell_out` therefore holds during configuration.
- R8: Any four-input function can be loaded. A table with only entry 15 set gives the four-input AND. A table holding odd parity of the index gives the four-input XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration mode: shifts the chain on each clock |
| cfg_din | input | 1 | Serial configuration data in |
| lut_in | input | 4 | Logic inputs, used as the table address |
| cfg_dout | output | 1 | Serial configuration data out (the mode bit) |
| cell_out | output | 1 | Cell output, combinational or registered |

## Verification
The main function is tried with four kinds of input pattern:
- A full sweep of all sixteen addresses over a table with irregular contents. This shows whether the load order and the address bit order are correct, because a reversed stream or swapped select bits gives a different output.
- An AND table. It tells a single-minterm function apart from its neighbours.
- A parity table in registered mode. It tells the one-cycle registered path apart from the raw path.
- Long random runs that interleave shifting and normal cycles at random. These show whether partial shifts corrupt the table, and whether the register wrongly samples while configuration is active.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int unsigned DEF_INPUTS = 4;

    typedef enum logic {
        OSEL_COMB = 1'b0,
        OSEL_REG  = 1'b1
    } osel_e;

    typedef struct packed {
        logic  lut_bit;
        osel_e mode;
    } cell_sel_t;

    function automatic int unsigned table_depth(input int unsigned n_in);
        return 32'd1 << n_in;
    endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain
    import lut_cell_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [DEPTH-1:0] tbl,
    output osel_e            mode,
    output logic             shift_out
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic nxt;
        if (i == 0) begin : g_head
            assign nxt = shift_in;
        end else begin : g_body
            assign nxt = tbl[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)           tbl[i] <= 1'b0;
            else if (shift_en) tbl[i] <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           mode <= OSEL_COMB;
        else if (shift_en) mode <= osel_e'(tbl[DEPTH-1]);
    end

    assign shift_out = mode;

    // R1: reset clears the configuration
    a_r1_cfg_clear: assert property (@(posedge clk)
        rst |=> (tbl == '0 && mode == OSEL_COMB));
    // R2: serial input lands in entry 0
    a_r2_head_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> tbl[0] == $past(shift_in));
    // R2: last table entry moves into the mode bit
    a_r2_tail_to_mode: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> mode == osel_e'($past(tbl[DEPTH-1])));
    // R3: configuration holds outside configuration mode
    a_r3_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(tbl) && $stable(mode)));

endmodule

// File: rtl/lut_mux.sv
module lut_mux
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned DEPTH = 16
) (
    input  logic [DEPTH-1:0] tbl,
    input  logic [N_IN-1:0]  sel,
    output logic             y
);

    always_comb y = tbl[sel];

endmodule

// File: rtl/out_stage.sv
module out_stage
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  cell_sel_t sel_in,
    output logic      cell_out
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (!hold) q <= sel_in.lut_bit;
    end

    always_comb cell_out = (sel_in.mode == OSEL_REG) ? q : sel_in.lut_bit;

    // R1: register clears on reset
    a_r1_reg_clear: assert property (@(posedge clk)
        rst |=> q == 1'b0);
    // R6: register samples the table result outside configuration mode
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        !hold |=> q == $past(sel_in.lut_bit));
    // R7: register frozen during configuration
    a_r7_reg_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int unsigned N_IN = DEF_INPUTS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] lut_in,
    output logic            cfg_dout,
    output logic            cell_out
);

    localparam int unsigned DEPTH = table_depth(N_IN);

    logic [DEPTH-1:0] tbl;
    osel_e            mode;
    cell_sel_t        sel;
    logic             lut_bit;

    cfg_chain #(.DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_en),
        .shift_in  (cfg_din),
        .tbl       (tbl),
        .mode      (mode),
        .shift_out (cfg_dout)
    );

    lut_mux #(.N_IN(N_IN), .DEPTH(DEPTH)) u_mux (
        .tbl (tbl),
        .sel (lut_in),
        .y   (lut_bit)
    );

    always_comb begin
        sel.lut_bit = lut_bit;
        sel.mode    = mode;
    end

    out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .hold     (cfg_en),
        .sel_in   (sel),
        .cell_out (cell_out)
    );

    // R5: in combinational mode the output follows the table with no clock
    a_r5_comb_path: assert property (@(posedge clk) disable iff (rst)
        (mode == OSEL_COMB) |-> cell_out == tbl[lut_in]);

endmodule

// File: tb/test_lut_cell.sv
module test_lut_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] lut_in = 4'd0;
    logic       cfg_dout;
    logic       cell_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] m_tbl  = '0;
    logic        m_osel = 1'b0;
    logic        m_q    = 1'b0;

    always #10 clk = ~clk;

    lut_cell i_lut_cell (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .lut_in   (lut_in),
        .cfg_dout (cfg_dout),
        .cell_out (cell_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(input logic [3:0] a);
        return m_osel ? m_q : m_tbl[a];
    endfunction

    function automatic logic f_and(input logic [3:0] a);
        return &a;
    endfunction

    function automatic logic f_xor(input logic [3:0] a);
        return ^a;
    endfunction

    task automatic model_edge(input logic en, input logic din, input logic [3:0] a);
        if (en) begin
            m_osel = m_tbl[15];
            m_tbl  = {m_tbl[14:0], din};
        end else begin
            m_q = m_tbl[a];
        end
    endtask

    task automatic cyc(input logic en, input logic din, input logic [3:0] a);
        @(negedge clk);
        cfg_en = en; cfg_din = din; lut_in = a;
        #2;
        if (m_osel) chk(en ? "R7 cell_out frozen" : "R6 registered", cell_out, exp_out(a));
        else        chk("R5 comb", cell_out, exp_out(a));
        chk(en ? "R2 cfg_dout" : "R3 cfg_dout", cfg_dout, m_osel);
        @(posedge clk);
        model_edge(en, din, a);
    endtask

    task automatic load(input logic [15:0] tt, input logic osel);
        for (int k = 0; k < 17; k++) begin
            cyc(1'b1, (k == 0) ? osel : tt[16-k], 4'($urandom));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] tt;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 cell_out after reset", cell_out, 1'b0);
        chk("R1 cfg_dout after reset", cfg_dout, 1'b0);

        // R4: irregular table, full address sweep, combinational mode
        tt = 16'hA5C3;
        load(tt, 1'b0);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            cfg_en = 1'b0; lut_in = 4'(a);
            #2;
            chk("R4 load order", cell_out, tt[a]);
            @(posedge clk);
            model_edge(1'b0, 1'b0, 4'(a));
        end

        // R8: AND in combinational mode
        load(16'h8000, 1'b0);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            cfg_en = 1'b0; lut_in = 4'(a);
            #2;
            chk("R8 and4", cell_out, f_and(4'(a)));
            @(posedge clk);
            model_edge(1'b0, 1'b0, 4'(a));
        end

        // R8 / R6: XOR in registered mode, output lags one edge
        for (int j = 0; j < 16; j++) tt[j] = f_xor(4'(j));
        load(tt, 1'b1);
        for (int a = 0; a < 16; a++) begin
            cyc(1'b0, 1'b0, 4'(a));
            @(negedge clk);
            #2;
            chk("R8 xor4 registered", cell_out, f_xor(4'(a)));
        end

        // R7: shifting while registered holds the output
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'($urandom), 4'($urandom));

        // R2: cfg_dout replays the stream seventeen shifts later
        load(16'h1234, 1'b1);
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_din = 1'b0;
            #2;
            chk("R2 replay", cfg_dout, (k == 0) ? 1'b1 : tt_bit(16'h1234, k));
            @(posedge clk);
            model_edge(1'b1, 1'b0, lut_in);
        end

        // random mix
        for (int n = 0; n < 4000; n++) begin
            cyc(($urandom % 4) == 0, 1'($urandom), 4'($urandom));
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1; cfg_en = 1'b0;
        @(posedge clk);
        m_tbl = '0; m_osel = 1'b0; m_q = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 cfg_dout mid reset", cfg_dout, 1'b0);
        chk("R1 cell_out mid reset", cell_out, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic tt_bit(input logic [15:0] t, input int k);
        return t[16-k];
    endfunction

endmodule